// File: doc/BRIEF.md
# UART Receive Word Packer with Idle Timeout

This block receives asynchronous serial data with fixed framing (one start bit, eight data bits sent least significant first, no parity, one stop bit). It gathers the received characters four at a time into 32-bit words and queues those words in a receive word FIFO. Software reads the FIFO through a small register port.

Software arms a receive transfer by writing a character count. The transfer closes when that many characters have arrived, or when the line stays quiet for a programmable number of character times (a stale event). When a transfer closes, any partly filled word is pushed with its unused bytes zeroed, and the number of characters taken in the transfer is held in a read-only snapshot register. The block includes its own baud tick generator, which runs at sixteen ticks per bit.

Top module: `uart_word_rx`

## Requirements
- R1: One bit lasts 16 x D clock cycles, where D is the baud divisor register (0 is treated as 1). A frame is received least significant bit first. A frame whose stop bit samples low yields no character, and the receiver waits for the line to return high before it looks for a new start bit.
- R2: Character k of a word (k = 0..3, in order of arrival) occupies bits 8k+7:8k of that word.
- R3: Writing a nonzero value N to the count register (address 4) arms a transfer and sets status bit 2. When the Nth character arrives, bit 2 clears, the snapshot register (address 5) reads N, and any partial word is pushed with its unused bytes zero.
- R4: The stale timer runs while the stale event is enabled, a partial word or an armed transfer is pending, and no frame is in progress. It restarts on each character. After T character times of quiet (T is the timeout register at address 6; 0 acts as 1), a stale event pushes the partial word zero padded, ends an armed transfer with the snapshot equal to the characters received in it, and sets ISR (address 2) bit 0.
- R5: Command bit 5 disables the stale event: a pending partial word is then neither pushed nor flagged. Command bit 4 enables it, and command bit 3 clears ISR bit 0. ISR bit 0 stays set until it is cleared.
- R6: Status (address 1) bit 0 is high exactly while the FIFO holds at least one word. A read of address 3 returns the oldest word and removes it.
- R7: When a full word must be pushed into a full FIFO, that word is lost and status bit 1 sets. The FIFO keeps the older words. Bit 1 stays set across reads until command bit 2 is written.
- R8: Command bit 1 (receiver reset) empties the FIFO and discards the partial word, the character count and any armed transfer.
- R9: Characters arriving before command bit 0 (receiver enable) has been written are ignored. Status bit 3 reads the enable state.
- R10: The command register is address 0, written only. The baud divisor is address 7 and resets to 1. After reset, the status, ISR and snapshot registers all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_in | input | 1 | Serial receive line, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at address 3) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the address |

## Verification
The assertions assume that software never arms a transfer and resets the receiver in the same cycle, and that the serial line idles high between frames. With those assumptions, the transfer counter never reaches the armed count while the transfer is still open. The bench drives only well-formed frames at a fixed divisor, apart from one deliberately bad stop bit, which it follows with a full idle period. Register accesses are spaced apart, and random transfers use exact counts of 1 to 11 characters sent back to back, so the stale timer cannot fire in the middle of a transfer.

// File: rtl/uwp_pkg.sv
// Shared constants and types for the UART receive word packer.
package uwp_pkg;
    // Register addresses
    localparam logic [2:0] ADDR_CMD   = 3'd0;
    localparam logic [2:0] ADDR_STAT  = 3'd1;
    localparam logic [2:0] ADDR_ISR   = 3'd2;
    localparam logic [2:0] ADDR_DATA  = 3'd3;
    localparam logic [2:0] ADDR_XCNT  = 3'd4;
    localparam logic [2:0] ADDR_SNAP  = 3'd5;
    localparam logic [2:0] ADDR_STALE = 3'd6;
    localparam logic [2:0] ADDR_BAUD  = 3'd7;

    // Command bit positions
    localparam int CMD_RX_EN     = 0;
    localparam int CMD_RX_RST    = 1;
    localparam int CMD_ERR_CLR   = 2;
    localparam int CMD_STALE_CLR = 3;
    localparam int CMD_STALE_ON  = 4;
    localparam int CMD_STALE_OFF = 5;

    // Oversampling and frame length
    localparam int OSR        = 16;
    localparam int FRAME_BITS = 10;

    typedef enum logic [2:0] {
        F_IDLE,
        F_START,
        F_DATA,
        F_STOP,
        F_BREAK
    } frame_state_e;
endpackage

// File: rtl/uwp_tick_gen.sv
// Baud tick generator: one-cycle tick every div clocks (div 0 acts as 1).
// Assumes div is changed only while the line is idle.
module uwp_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_comb tick = (div <= DIV_W'(1)) || (cnt >= div - DIV_W'(1));

    // Free-running divider counter
    always_ff @(posedge clk) begin
        if (!rst_n || tick) cnt <= '0;
        else                cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/uwp_rx_frame.sv
// Serial frame receiver, 8-N-1, sampled on 16x ticks near mid-bit.
// Assumes rx_in is asynchronous (double-synchronised here). A bad stop bit
// drops the character and waits for the line to return high.
module uwp_rx_frame #(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    input  logic       rx_in,
    output logic       busy,
    output logic       ch_valid,
    output logic [7:0] ch_data
);
    import uwp_pkg::*;
    localparam int OSW  = $clog2(OSR);
    localparam int HALF = OSR / 2;

    logic [1:0]     sync_q;
    logic           rx_s;
    frame_state_e   state;
    logic [OSW-1:0] tcnt;
    logic [2:0]     bitn;
    logic [7:0]     shreg;

    always_comb rx_s = sync_q[1];
    always_comb busy = (state != F_IDLE);
    always_comb ch_data = shreg;

    // Two-stage input synchroniser, idle high
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_in};
    end

    // Frame state machine
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state    <= F_IDLE;
            tcnt     <= '0;
            bitn     <= '0;
            shreg    <= '0;
            ch_valid <= 1'b0;
        end else begin
            ch_valid <= 1'b0;
            case (state)
                F_IDLE: begin
                    if (!rx_s) begin
                        state <= F_START;
                        tcnt  <= '0;
                    end
                end
                F_START: begin
                    if (tick) begin
                        if (tcnt == OSW'(HALF - 1)) begin
                            tcnt <= '0;
                            bitn <= '0;
                            state <= rx_s ? F_IDLE : F_DATA;
                        end else begin
                            tcnt <= tcnt + OSW'(1);
                        end
                    end
                end
                F_DATA: begin
                    if (tick) begin
                        if (tcnt == OSW'(OSR - 1)) begin
                            tcnt  <= '0;
                            shreg <= {rx_s, shreg[7:1]};
                            if (bitn == 3'd7) state <= F_STOP;
                            else              bitn  <= bitn + 3'd1;
                        end else begin
                            tcnt <= tcnt + OSW'(1);
                        end
                    end
                end
                F_STOP: begin
                    if (tick) begin
                        if (tcnt == OSW'(OSR - 1)) begin
                            tcnt <= '0;
                            if (rx_s) begin
                                ch_valid <= 1'b1;
                                state    <= F_IDLE;
                            end else begin
                                state    <= F_BREAK;
                            end
                        end else begin
                            tcnt <= tcnt + OSW'(1);
                        end
                    end
                end
                F_BREAK: begin
                    if (rx_s) state <= F_IDLE;
                end
                default: state <= F_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uwp_stale_timer.sv
// Idle timer counted in character times; pulses evt after limit quiet
// character times. Assumes restart is asserted on every received character.
module uwp_stale_timer #(
    parameter int TMO_W      = 8,
    parameter int CHAR_TICKS = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             restart,
    input  logic [TMO_W-1:0] limit,
    output logic             evt
);
    localparam int SUB_W = $clog2(CHAR_TICKS);

    logic [SUB_W-1:0] sub;
    logic [TMO_W:0]   chars;
    logic [TMO_W:0]   lim_eff;

    always_comb lim_eff = (limit == '0) ? (TMO_W+1)'(1) : {1'b0, limit};

    // Character-time sub-counter and quiet-character counter
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            sub   <= '0;
            chars <= '0;
            evt   <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (run && tick) begin
                if (sub == SUB_W'(CHAR_TICKS - 1)) begin
                    sub <= '0;
                    if (chars + (TMO_W+1)'(1) >= lim_eff) begin
                        chars <= '0;
                        evt   <= 1'b1;
                    end else begin
                        chars <= chars + (TMO_W+1)'(1);
                    end
                end else begin
                    sub <= sub + SUB_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/uwp_word_fifo.sv
// Receive word FIFO. A push into a full FIFO is dropped unless a pop
// happens in the same cycle. The flush input empties it.
module uwp_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    always_comb begin
        empty   = (level == '0);
        full    = (level == LW'(DEPTH));
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        rdata   = mem[rptr];
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wptr] <= wdata;
    end

    // Pointers and level
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end
endmodule

// File: rtl/uart_word_rx.sv
// UART receive word packer: receives 8-N-1 characters, packs four per
// 32-bit word into a FIFO, closes transfers on a character count or an
// idle (stale) timeout, and keeps a snapshot of each transfer's count.
// Assumes register accesses are single-cycle strobes.
module uart_word_rx #(
    parameter int FIFO_DEPTH  = 8,
    parameter int CNT_W       = 16,
    parameter int TMO_W       = 8,
    parameter int DIV_W       = 16,
    parameter int TMO_RST     = 4,
    parameter int DIV_RST     = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_in,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    import uwp_pkg::*;
    localparam int CHAR_TICKS = OSR * FRAME_BITS;
    localparam int LW         = $clog2(FIFO_DEPTH + 1);

    // Configuration and state
    logic             rx_en, stale_en;
    logic [DIV_W-1:0] div_q;
    logic [TMO_W-1:0] tmo_q;
    logic [CNT_W-1:0] xcnt_q, snap_q, char_cnt;
    logic             xfer_active;
    logic [31:0]      pack_word;
    logic [1:0]       pack_fill;
    logic             overrun_q, stale_q;

    // Decoded commands and strobes
    logic cmd_wr, cmd_rx_en, cmd_rx_rst, cmd_err_clr, cmd_stale_clr;
    logic cmd_stale_on, cmd_stale_off, xcnt_wr;

    // Datapath nets
    logic        tick, busy, ch_raw, ch_valid, stale_evt, timer_run;
    logic [7:0]  ch_data;
    logic [31:0] merged, push_data, fifo_rdata;
    logic        cnt_hit, push, pop, fifo_empty, fifo_full, word_lost;
    logic [LW-1:0] fifo_lvl;

    always_comb begin
        cmd_wr        = reg_wr && (reg_addr == ADDR_CMD);
        cmd_rx_en     = cmd_wr && reg_wdata[CMD_RX_EN];
        cmd_rx_rst    = cmd_wr && reg_wdata[CMD_RX_RST];
        cmd_err_clr   = cmd_wr && reg_wdata[CMD_ERR_CLR];
        cmd_stale_clr = cmd_wr && reg_wdata[CMD_STALE_CLR];
        cmd_stale_on  = cmd_wr && reg_wdata[CMD_STALE_ON];
        cmd_stale_off = cmd_wr && reg_wdata[CMD_STALE_OFF];
        xcnt_wr       = reg_wr && (reg_addr == ADDR_XCNT);
    end

    uwp_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
    );

    uwp_rx_frame #(.OSR(OSR)) u_frame (
        .clk(clk), .rst_n(rst_n), .clr(cmd_rx_rst), .tick(tick),
        .rx_in(rx_in), .busy(busy), .ch_valid(ch_raw), .ch_data(ch_data)
    );

    always_comb begin
        ch_valid  = ch_raw && rx_en && !cmd_rx_rst;
        timer_run = stale_en && rx_en && !busy && (pack_fill != 2'd0 || xfer_active);
    end

    uwp_stale_timer #(.TMO_W(TMO_W), .CHAR_TICKS(CHAR_TICKS)) u_stale (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(timer_run),
        .restart(ch_valid || cmd_rx_rst || xcnt_wr || cmd_stale_off),
        .limit(tmo_q), .evt(stale_evt)
    );

    // Merge the incoming character into its byte lane and decide pushes
    always_comb begin
        merged = pack_word;
        merged[8*pack_fill +: 8] = ch_data;
        cnt_hit   = ch_valid && xfer_active && (char_cnt + CNT_W'(1) == xcnt_q);
        push      = !cmd_rx_rst &&
                    ((ch_valid && (pack_fill == 2'd3 || cnt_hit)) ||
                     (stale_evt && stale_en && pack_fill != 2'd0));
        push_data = ch_valid ? merged : pack_word;
        pop       = reg_rd && (reg_addr == ADDR_DATA);
        word_lost = push && fifo_full && !pop;
    end

    uwp_word_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(cmd_rx_rst), .push(push), .pop(pop),
        .wdata(push_data), .rdata(fifo_rdata), .empty(fifo_empty),
        .full(fifo_full), .level(fifo_lvl)
    );

    // Configuration registers and mode bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en    <= 1'b0;
            stale_en <= 1'b0;
            div_q    <= DIV_W'(DIV_RST);
            tmo_q    <= TMO_W'(TMO_RST);
            xcnt_q   <= '0;
        end else begin
            if (cmd_rx_en)     rx_en    <= 1'b1;
            if (cmd_stale_on)  stale_en <= 1'b1;
            if (cmd_stale_off) stale_en <= 1'b0;
            if (reg_wr && reg_addr == ADDR_BAUD)  div_q <= reg_wdata[DIV_W-1:0];
            if (reg_wr && reg_addr == ADDR_STALE) tmo_q <= reg_wdata[TMO_W-1:0];
            if (xcnt_wr) xcnt_q <= reg_wdata[CNT_W-1:0];
        end
    end

    // Word packing state
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_rx_rst) begin
            pack_word <= '0;
            pack_fill <= '0;
        end else if (push) begin
            pack_word <= '0;
            pack_fill <= '0;
        end else if (ch_valid) begin
            pack_word <= merged;
            pack_fill <= pack_fill + 2'd1;
        end
    end

    // Transfer tracking and snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_active <= 1'b0;
            char_cnt    <= '0;
            snap_q      <= '0;
        end else if (cmd_rx_rst) begin
            xfer_active <= 1'b0;
            char_cnt    <= '0;
        end else if (xcnt_wr) begin
            xfer_active <= (reg_wdata[CNT_W-1:0] != '0);
            char_cnt    <= '0;
        end else if (cnt_hit) begin
            xfer_active <= 1'b0;
            snap_q      <= char_cnt + CNT_W'(1);
        end else if (stale_evt && stale_en && xfer_active) begin
            xfer_active <= 1'b0;
            snap_q      <= char_cnt;
        end else if (ch_valid && xfer_active) begin
            char_cnt    <= char_cnt + CNT_W'(1);
        end
    end

    // Sticky error and interrupt flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun_q <= 1'b0;
            stale_q   <= 1'b0;
        end else begin
            if (cmd_err_clr) overrun_q <= 1'b0;
            if (word_lost)   overrun_q <= 1'b1;
            if (cmd_stale_clr) stale_q <= 1'b0;
            if (stale_evt && stale_en) stale_q <= 1'b1;
        end
    end

    // Read data mux
    always_comb begin
        case (reg_addr)
            ADDR_STAT:  reg_rdata = {28'd0, rx_en, xfer_active, overrun_q, !fifo_empty};
            ADDR_ISR:   reg_rdata = {31'd0, stale_q};
            ADDR_DATA:  reg_rdata = fifo_empty ? 32'd0 : fifo_rdata;
            ADDR_XCNT:  reg_rdata = 32'(xcnt_q);
            ADDR_SNAP:  reg_rdata = 32'(snap_q);
            ADDR_STALE: reg_rdata = 32'(tmo_q);
            ADDR_BAUD:  reg_rdata = 32'(div_q);
            default:    reg_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/uwp_chk.sv
// Assertion checker for uart_word_rx, attached by bind.
module uwp_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 16,
    parameter int LW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LW-1:0]    fifo_lvl,
    input logic [1:0]       pack_fill,
    input logic             rx_rst,
    input logic             err_clr,
    input logic             lost,
    input logic             overrun,
    input logic             stale_flag,
    input logic             stale_clr,
    input logic             xfer_active,
    input logic [CNT_W-1:0] char_cnt,
    input logic [CNT_W-1:0] xcnt,
    input logic [CNT_W-1:0] snap
);
    // R7
    fifo_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_lvl <= LW'(DEPTH));
    // R8
    rx_reset_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst |=> (fifo_lvl == '0) && (pack_fill == 2'd0));
    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !err_clr |=> overrun);
    // R7
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !lost |=> !overrun);
    // R5
    stale_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stale_flag && !stale_clr |=> stale_flag);
    // R3
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> $stable(snap));
    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active |-> char_cnt < xcnt);
endmodule

bind uart_word_rx uwp_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_lvl(fifo_lvl), .pack_fill(pack_fill),
    .rx_rst(cmd_rx_rst), .err_clr(cmd_err_clr), .lost(word_lost),
    .overrun(overrun_q), .stale_flag(stale_q), .stale_clr(cmd_stale_clr),
    .xfer_active(xfer_active), .char_cnt(char_cnt), .xcnt(xcnt_q), .snap(snap_q)
);

// File: tb/uart_word_rx_tb.sv
// Self-checking bench for uart_word_rx: directed corner cases plus
// seeded random transfers.
module uart_word_rx_tb;
    localparam int DIV   = 2;
    localparam int BIT   = 16 * DIV;
    localparam int CHART = 10 * BIT;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_in = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] bytes [0:63];

    always #5 clk = ~clk;

    uart_word_rx #(.FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FIL_ %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop);
        rx_in = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_in = b[i];
            repeat (BIT) @(negedge clk);
        end
        rx_in = stop;
        repeat (BIT) @(negedge clk);
        rx_in = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // Expected word from n bytes starting at index base (R2)
    function automatic logic [31:0] exp_word(input int base, input int n);
        logic [31:0] w = '0;
        for (int k = 0; k < n; k++) w[8*k +: 8] = bytes[base + k];
        return w;
    endfunction

    task automatic send_n(input int n);
        for (int i = 0; i < n; i++) send_byte(bytes[i], 1'b1);
    endtask

    task automatic read_words(input int n, input string req);
        logic [31:0] d;
        for (int w = 0; w < (n + 3) / 4; w++) begin
            reg_read(3'd3, d);
            chk(req, d, exp_word(4 * w, (n - 4 * w > 4) ? 4 : n - 4 * w));
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        reg_read(3'd1, d); chk("R10 status", d, 32'd0);
        reg_read(3'd2, d); chk("R10 isr", d, 32'd0);
        reg_read(3'd5, d); chk("R10 snap", d, 32'd0);
        reg_read(3'd7, d); chk("R10 baud", d, 32'd1);
        reg_write(3'd7, DIV);
        reg_write(3'd6, 32'd2);
        reg_write(3'd0, 32'h10);

        // R9 ignored before enable
        reg_write(3'd4, 32'd1);
        send_byte(8'h5A, 1'b1);
        repeat (CHART) @(negedge clk);
        reg_read(3'd1, d); chk("R9 rxrdy before enable", d[0], 1'b0);
        reg_write(3'd4, 32'd0);
        reg_write(3'd0, 32'h01);
        reg_read(3'd1, d); chk("R9 enable bit", d[3], 1'b1);

        // R3 R2 random exact-count transfers
        for (int t = 0; t < 6; t++) begin
            int n = 1 + int'($urandom % 11);
            for (int i = 0; i < n; i++) bytes[i] = 8'($urandom);
            reg_write(3'd4, n);
            reg_read(3'd1, d); chk("R3 armed", d[2], 1'b1);
            send_n(n);
            reg_read(3'd1, d); chk("R3 done", d[2], 1'b0);
            chk("R6 rxrdy", d[0], 1'b1);
            reg_read(3'd5, d); chk("R3 snap", d, n);
            read_words(n, "R2 word");
            reg_read(3'd1, d); chk("R6 empty", d[0], 1'b0);
        end

        // R4 stale with partial word
        for (int i = 0; i < 5; i++) bytes[i] = 8'($urandom);
        reg_write(3'd4, 32'd100);
        send_n(5);
        repeat (3 * CHART) @(negedge clk);
        reg_read(3'd2, d); chk("R4 isr", d, 32'd1);
        reg_read(3'd5, d); chk("R4 snap", d, 32'd5);
        reg_read(3'd1, d); chk("R4 closed", d[2], 1'b0);
        read_words(5, "R4 word");
        reg_write(3'd0, 32'h08);
        reg_read(3'd2, d); chk("R5 clear", d, 32'd0);

        // R5 disabled stale holds partial word
        reg_write(3'd0, 32'h20);
        for (int i = 0; i < 3; i++) bytes[i] = 8'($urandom);
        reg_write(3'd4, 32'd100);
        send_n(3);
        repeat (3 * CHART) @(negedge clk);
        reg_read(3'd2, d); chk("R5 disabled isr", d, 32'd0);
        reg_read(3'd1, d); chk("R5 disabled rxrdy", d[0], 1'b0);
        reg_write(3'd0, 32'h10);
        repeat (3 * CHART) @(negedge clk);
        reg_read(3'd2, d); chk("R5 enabled isr", d, 32'd1);
        reg_read(3'd5, d); chk("R5 snap", d, 32'd3);
        read_words(3, "R5 word");
        reg_write(3'd0, 32'h08);

        // R1 bad stop bit dropped
        reg_write(3'd4, 32'd1);
        send_byte(8'h33, 1'b0);
        repeat (CHART) @(negedge clk);
        reg_read(3'd1, d); chk("R1 bad stop", d[0], 1'b0);
        bytes[0] = 8'h44;
        send_n(1);
        reg_read(3'd5, d); chk("R1 snap", d, 32'd1);
        read_words(1, "R1 word");

        // R7 overrun
        reg_write(3'd4, 32'd0);
        for (int i = 0; i < 4 * (DEPTH + 1); i++) bytes[i] = 8'($urandom);
        send_n(4 * (DEPTH + 1));
        reg_read(3'd1, d); chk("R7 overrun set", d[1:0], 2'b11);
        read_words(4 * DEPTH, "R7 kept words");
        reg_read(3'd1, d); chk("R7 sticky", d[1:0], 2'b10);
        reg_write(3'd0, 32'h04);
        reg_read(3'd1, d); chk("R7 cleared", d[1], 1'b0);

        // R8 receiver reset flush
        for (int i = 0; i < 6; i++) bytes[i] = 8'($urandom);
        send_n(6);
        reg_read(3'd1, d); chk("R8 before reset", d[0], 1'b1);
        reg_write(3'd0, 32'h02);
        reg_read(3'd1, d); chk("R8 flushed", d[0], 1'b0);
        for (int i = 0; i < 2; i++) bytes[i] = 8'($urandom);
        reg_write(3'd4, 32'd2);
        send_n(2);
        read_words(2, "R8 partial discarded");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule